// File: doc/BRIEF.md
# Flash Region CRC-32 Engine

This block computes a 32-bit checksum over a page-aligned range of flash so that software can confirm the result of an erase or a program operation. Software writes a first address, a limit address and a seed into three configuration registers. It then writes the control register with the enable bit and the go bit set. The engine fetches the range one 32-bit word at a time over a private read port, with a valid/ready request channel and a response strobe. Because the read port sits behind any read-back protection, the checksum is available even for locked regions.

Each fetched word is folded into the running remainder in a single cycle. The fold is a 32-stage combinational chain, and it gives the same value as the one-bit-per-step shift-register method. When the range is exhausted, the engine clears the go bit and raises a sticky interrupt flag. In the same cycle it publishes the inverted remainder in the result register. The flash array itself lies outside the block.

Top module: `flash_crc_engine`

## Requirements
- R1: After reset the control readback is 0, the interrupt flag is 0, the result is 0 and no read request is issued.
- R2: A control write (select 0) whose enable bit (bit 15) is 0 leaves the go bit (bit 14 of the control readback) at 0, issues no read request and leaves the interrupt flag unchanged.
- R3: A control write with bits 15 and 14 both set starts a run. The go bit then reads 1 until the run ends. In the cycle it returns to 0, the interrupt flag is 1 and the new result is visible.
- R4: The first address (select 1) and the limit address (select 2) keep only bits ADDR_W-1..12; bits 11..0 read as zero. Read requests cover every word address from the first address up to, but not including, the limit, in ascending order and 4 bytes apart.
- R5: The result equals the inverse of a 32-bit register preloaded with the inverse of the seed (select 3). For each word, 32 steps are applied, most significant data bit first. In each step, the data bit is XORed with register bit 0, the register shifts right with 0 into bit 31, and it is XORed with 0xEDB88320 when that XOR was 1.
- R6: When the limit is less than or equal to the first address, the run ends without any read request, and the result equals the seed.
- R7: The result register keeps its previous value throughout a run and changes only in the cycle in which the go bit falls.
- R8: Control writes made while the go bit is 1 are ignored. The enable and go bits and the running computation are unaffected.
- R9: The interrupt flag stays at 1 after a run until the next accepted start clears it.
- R10: A pending read request keeps valid high and its address stable until ready is seen, and the engine never has more than one read outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 control, 1 first address, 2 limit address, 3 seed |
| cfg_wr_data | input | 32 | Configuration write data |
| ctrl_o | output | 16 | Control readback: bit 15 enable, bit 14 go, other bits 0 |
| irq_o | output | 1 | Sticky checksum-ready interrupt flag |
| crc_result_o | output | 32 | Most recent checksum |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | ADDR_W | Byte address of the requested word |
| rd_rsp_valid_i | input | 1 | Read data strobe |
| rd_rsp_data_i | input | 32 | Read data word |

## Verification
On every cycle, the assertions check the following: the request handshake stays stable and word-aligned, and no request appears outside a run. The go bit ignores control writes that lack the enable bit. The go bit falls only together with the interrupt flag, and the result moves only at that instant. Only the bench scenarios can show that the checksum value matches the bit-serial method and that the ascending address sequence covers exactly the requested pages under stalls and latency. They also show the empty and inverted ranges, and that the flag persists until the next start.

// File: rtl/flash_crc_pkg.sv
// Shared constants for the flash region CRC engine.
// Assumes a 32-bit data word and the reflected CRC-32 polynomial.
package flash_crc_pkg;
    localparam int          WORD_W     = 32;
    localparam logic [31:0] CRC_POLY   = 32'hEDB8_8320;
    localparam int          EN_BIT     = 15;
    localparam int          GO_BIT     = 14;
    localparam int          CTRL_W     = 16;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_FIRST = 2'd1,
        SEL_LIMIT = 2'd2,
        SEL_SEED  = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_REQ,
        WK_WAIT,
        WK_DONE
    } walk_state_e;
endpackage

// File: rtl/crc_fold.sv
// Folds one data word into a reflected CRC remainder in one cycle.
// Unrolls the bit-serial method: step g takes data bit WORD_W-1-g.
// Purely combinational; assumes WORD_W matches the polynomial width.
module crc_fold
    import flash_crc_pkg::*;
(
    input  logic [WORD_W-1:0] crc_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] crc_o
);
    logic [WORD_W-1:0] stage [0:WORD_W];

    assign stage[0] = crc_i;

    for (genvar g = 0; g < WORD_W; g++) begin : g_step
        logic fb;
        // one shift step: feedback bit picks whether the polynomial is applied
        assign fb = data_i[WORD_W-1-g] ^ stage[g][0];
        assign stage[g+1] = {1'b0, stage[g][WORD_W-1:1]} ^ (fb ? CRC_POLY : '0);
    end

    assign crc_o = stage[WORD_W];
endmodule

// File: rtl/crc_cfg_regs.sv
// Configuration and control state of the CRC engine.
// Holds the page-aligned address bounds, the seed, the enable and
// go bits and the sticky interrupt flag. Control writes are ignored
// while a run is in progress; done_i comes from the walker.
module crc_cfg_regs
    import flash_crc_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              done_i,
    output logic              launch_o,
    output logic              enable_o,
    output logic              go_o,
    output logic              irq_o,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] limit_o,
    output logic [WORD_W-1:0] seed_o
);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic [PAGE_W-1:0] first_pg_q, limit_pg_q;
    logic              ctrl_wr;

    assign ctrl_wr  = wr_en_i && (wr_sel_i == SEL_CTRL) && !go_o;
    assign launch_o = ctrl_wr && wr_data_i[EN_BIT] && wr_data_i[GO_BIT];
    assign first_o  = {first_pg_q, {PAGE_BITS{1'b0}}};
    assign limit_o  = {limit_pg_q, {PAGE_BITS{1'b0}}};

    // register writes, run launch and run completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_pg_q <= '0;
            limit_pg_q <= '0;
            seed_o     <= '0;
            enable_o   <= 1'b0;
            go_o       <= 1'b0;
            irq_o      <= 1'b0;
        end else begin
            if (wr_en_i && wr_sel_i == SEL_FIRST) first_pg_q <= wr_data_i[ADDR_W-1:PAGE_BITS];
            if (wr_en_i && wr_sel_i == SEL_LIMIT) limit_pg_q <= wr_data_i[ADDR_W-1:PAGE_BITS];
            if (wr_en_i && wr_sel_i == SEL_SEED)  seed_o     <= wr_data_i;
            if (ctrl_wr) begin
                enable_o <= wr_data_i[EN_BIT];
                go_o     <= launch_o;
            end
            if (launch_o) irq_o <= 1'b0;
            if (done_i) begin
                go_o  <= 1'b0;
                irq_o <= 1'b1;
            end
        end
    end

    // R2
    no_go_without_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_CTRL && !go_o && !wr_data_i[EN_BIT]) |=> !go_o);
    // R8
    busy_ctrl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && !done_i) |=> (go_o && $stable(enable_o)));
endmodule

// File: rtl/crc_walker.sv
// Sequences word reads over [first, limit) and folds each word.
// One request outstanding at a time; responses are expected only
// after a request has been accepted. Publishes the inverted
// remainder and pulses done_o for one cycle when the range ends.
module crc_walker
    import flash_crc_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic [ADDR_W-1:0] first_i,
    input  logic [ADDR_W-1:0] limit_i,
    input  logic [WORD_W-1:0] seed_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    input  logic              rsp_valid_i,
    input  logic [WORD_W-1:0] rsp_data_i,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

    walk_state_e       state_q;
    logic [ADDR_W-1:0] addr_q, limit_q, addr_nx;
    logic [WORD_W-1:0] crc_q, crc_nx;

    crc_fold i_fold (
        .crc_i  (crc_q),
        .data_i (rsp_data_i),
        .crc_o  (crc_nx)
    );

    assign addr_nx     = addr_q + STEP;
    assign req_valid_o = (state_q == WK_REQ);
    assign req_addr_o  = addr_q;
    assign done_o      = (state_q == WK_DONE);

    // range walk state machine with remainder update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WK_IDLE;
            addr_q   <= '0;
            limit_q  <= '0;
            crc_q    <= '0;
            result_o <= '0;
        end else begin
            unique case (state_q)
                WK_IDLE: if (launch_i) begin
                    crc_q   <= ~seed_i;
                    addr_q  <= first_i;
                    limit_q <= limit_i;
                    state_q <= (limit_i > first_i) ? WK_REQ : WK_DONE;
                end
                WK_REQ:  if (req_ready_i) state_q <= WK_WAIT;
                WK_WAIT: if (rsp_valid_i) begin
                    crc_q   <= crc_nx;
                    addr_q  <= addr_nx;
                    state_q <= (addr_nx >= limit_q) ? WK_DONE : WK_REQ;
                end
                WK_DONE: begin
                    result_o <= ~crc_q;
                    state_q  <= WK_IDLE;
                end
                default: state_q <= WK_IDLE;
            endcase
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));
    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=> !req_valid_o);
    // R4
    req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_addr_o[1:0] == 2'b00));
endmodule

// File: rtl/flash_crc_engine.sv
// Top of the flash region CRC-32 engine.
// Connects the configuration registers to the range walker. The
// flash read port is internal, so it is unaffected by read-back
// protection. Assumes ADDR_W exceeds PAGE_BITS.
module flash_crc_engine
    import flash_crc_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [31:0]       cfg_wr_data,
    output logic [15:0]       ctrl_o,
    output logic              irq_o,
    output logic [31:0]       crc_result_o,
    output logic              rd_req_valid_o,
    input  logic              rd_req_ready_i,
    output logic [ADDR_W-1:0] rd_req_addr_o,
    input  logic              rd_rsp_valid_i,
    input  logic [31:0]       rd_rsp_data_i
);
    logic              launch, enable, go, done;
    logic [ADDR_W-1:0] first, limit;
    logic [WORD_W-1:0] seed;

    crc_cfg_regs #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_wr_en),
        .wr_sel_i  (cfg_wr_sel),
        .wr_data_i (cfg_wr_data),
        .done_i    (done),
        .launch_o  (launch),
        .enable_o  (enable),
        .go_o      (go),
        .irq_o     (irq_o),
        .first_o   (first),
        .limit_o   (limit),
        .seed_o    (seed)
    );

    crc_walker #(.ADDR_W(ADDR_W)) i_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .first_i     (first),
        .limit_i     (limit),
        .seed_i      (seed),
        .req_valid_o (rd_req_valid_o),
        .req_ready_i (rd_req_ready_i),
        .req_addr_o  (rd_req_addr_o),
        .rsp_valid_i (rd_rsp_valid_i),
        .rsp_data_i  (rd_rsp_data_i),
        .done_o      (done),
        .result_o    (crc_result_o)
    );

    assign ctrl_o = {enable, go, {(CTRL_W-2){1'b0}}};

    // R3
    go_fall_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go) |-> irq_o);
    // R7
    result_moves_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(crc_result_o) |-> $fell(go));
    // R6
    req_only_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o |-> go);
endmodule

// File: tb/test_flash_crc_engine.sv
module test_flash_crc_engine;
    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [1:0]        cfg_wr_sel = '0;
    logic [31:0]       cfg_wr_data = '0;
    logic [15:0]       ctrl_o;
    logic              irq_o;
    logic [31:0]       crc_result_o;
    logic              rd_req_valid_o;
    logic              rd_req_ready_i = 1'b0;
    logic [ADDR_W-1:0] rd_req_addr_o;
    logic              rd_rsp_valid_i = 1'b0;
    logic [31:0]       rd_rsp_data_i = '0;

    int total = 0;
    int bad = 0;

    // flash model state
    int  req_count = 0;
    int  addr_bad = 0;
    int  latency = 0;
    bit  stall_mode = 0;
    bit  pend = 0;
    int  cnt = 0;
    int  cyc = 0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [ADDR_W-1:0] exp_addr = '0;

    always #10 clk = ~clk; // 50 MHz

    flash_crc_engine #(.ADDR_W(ADDR_W)) i_flash_crc_engine (.*);

    function automatic logic [31:0] flash_word(input logic [ADDR_W-1:0] a);
        logic [31:0] x;
        x = 32'(a);
        return (x * 32'h9E37_79B1) ^ {x[15:0], 16'hC3A5};
    endfunction

    // reference checksum per the bit-serial method
    function automatic logic [31:0] ref_crc(input logic [31:0] seed,
                                            input int first, input int limit);
        logic [31:0] sr, w;
        logic b;
        sr = ~seed;
        for (int a = first; a < limit; a += 4) begin
            w = flash_word(ADDR_W'(a));
            for (int k = 31; k >= 0; k--) begin
                b  = w[k] ^ sr[0];
                sr = sr >> 1;
                if (b) sr = sr ^ 32'hEDB8_8320;
            end
        end
        return ~sr;
    endfunction

    // flash model: driven at the falling edge
    always @(negedge clk) begin
        cyc++;
        rd_rsp_valid_i = 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                rd_rsp_valid_i = 1'b1;
                rd_rsp_data_i  = flash_word(paddr);
                pend = 0;
            end else cnt--;
        end
        rd_req_ready_i = !pend && (!stall_mode || (cyc % 3 == 0));
        if (rd_req_valid_o && rd_req_ready_i) begin
            pend  = 1;
            paddr = rd_req_addr_o;
            cnt   = latency;
            req_count++;
            if (rd_req_addr_o != exp_addr) addr_bad++;
            exp_addr = rd_req_addr_o + 4;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (ctrl_o[14] && n < 50000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_range(input string req, input logic [31:0] seed,
                             input int first, input int limit,
                             input int first_al, input int limit_al);
        logic [31:0] prev;
        int words;
        prev = crc_result_o;
        cfg_write(2'd1, 32'(first));
        cfg_write(2'd2, 32'(limit));
        cfg_write(2'd3, seed);
        req_count = 0; addr_bad = 0; exp_addr = ADDR_W'(first_al);
        cfg_write(2'd0, 32'h0000_C000);
        if (limit_al > first_al) begin
            check({req, " go set during run"}, 32'(ctrl_o[14]), 32'd1);
            check({req, " R7 result held during run"}, crc_result_o, prev);
        end
        wait_done();
        words = (limit_al > first_al) ? (limit_al - first_al) / 4 : 0;
        check({req, " R3 go cleared"}, 32'(ctrl_o[14]), 32'd0);
        check({req, " R3 irq set"}, 32'(irq_o), 32'd1);
        check({req, " R5 result"}, crc_result_o, ref_crc(seed, first_al, limit_al));
        check({req, " R4 word count"}, 32'(req_count), 32'(words));
        check({req, " R4 address order"}, 32'(addr_bad), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 ctrl", 32'(ctrl_o), 32'd0);
        check("R1 irq", 32'(irq_o), 32'd0);
        check("R1 result", crc_result_o, 32'd0);
        check("R1 no request", 32'(rd_req_valid_o), 32'd0);
    endtask

    task automatic t_disabled_start();
        req_count = 0;
        cfg_write(2'd1, 32'h1000);
        cfg_write(2'd2, 32'h2000);
        cfg_write(2'd0, 32'h0000_4000);
        repeat (5) @(negedge clk);
        check("R2 go stays clear", 32'(ctrl_o[14]), 32'd0);
        check("R2 no request", 32'(req_count), 32'd0);
        check("R2 irq unchanged", 32'(irq_o), 32'd0);
    endtask

    task automatic t_irq_sticky();
        repeat (20) @(negedge clk);
        check("R9 irq held", 32'(irq_o), 32'd1);
        cfg_write(2'd2, 32'h3000);
        cfg_write(2'd0, 32'h0000_C000);
        check("R9 irq cleared by start", 32'(irq_o), 32'd0);
        wait_done();
        check("R9 irq after run", 32'(irq_o), 32'd1);
    endtask

    task automatic t_busy_ctrl();
        logic [31:0] seed = 32'h1357_9BDF;
        cfg_write(2'd1, 32'h4000);
        cfg_write(2'd2, 32'h5000);
        cfg_write(2'd3, seed);
        req_count = 0; addr_bad = 0; exp_addr = 'h4000;
        cfg_write(2'd0, 32'h0000_C000);
        repeat (10) @(negedge clk);
        cfg_write(2'd0, 32'h0000_0000);
        check("R8 go kept", 32'(ctrl_o[14]), 32'd1);
        check("R8 enable kept", 32'(ctrl_o[15]), 32'd1);
        wait_done();
        check("R8 result intact", crc_result_o, ref_crc(seed, 'h4000, 'h5000));
        check("R8 word count", 32'(req_count), 32'd1024);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled_start();
        run_range("R5 one page", 32'h0, 'h1000, 'h2000, 'h1000, 'h2000);
        t_irq_sticky();
        stall_mode = 1; latency = 2;
        run_range("R4 unaligned two pages", 32'hFFFF_FFFF, 'h1ABC, 'h3FFF, 'h1000, 'h3000);
        stall_mode = 0; latency = 0;
        run_range("R6 empty range", 32'hA5C3_0F1E, 'h8000, 'h8000, 'h8000, 'h8000);
        check("R6 result is seed", crc_result_o, 32'hA5C3_0F1E);
        run_range("R6 inverted range", 32'h0BAD_F00D, 'h9000, 'h2000, 'h9000, 'h2000);
        check("R6 inverted result is seed", crc_result_o, 32'h0BAD_F00D);
        t_busy_ctrl();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule